// File: doc/BRIEF.md
# Receive Special Character Detector

This block sits on the receive side of a UART, after the deserializer. It looks at each character that arrives with a valid strobe. It compares that character against four programmable software flow-control characters and against a special-character value. From the result it decides whether the character goes to the receive FIFO. It also produces pulses that pause or resume the local transmitter, and it holds a sticky special-character flag for the interrupt logic.

A two-bit compare mode picks which pair of flow-control characters is active. Pair A is the first XON/XOFF pair. Pair B is the second pair, whose XOFF value is also the special-character value. A separate enable turns special-character detection on. Because pair B's XOFF and the special character share one register, the mode decides two things when that character arrives. Under pair A it is stored in the FIFO and only flagged. Under pair B it is swallowed as a flow-control character and raises both an XOFF event and the special-character flag.

Top module: `rx_special_char`

## Requirements
- R1: Each character accepted with `rx_valid` that is not consumed as a flow-control character appears on `fifo_wr`/`fifo_data` one clock later with the same value. `fifo_wr` is low in the cycle after any cycle without `rx_valid`.
- R2: A character received with `rx_frame_err` high matches nothing. It is stored, and it raises no XON/XOFF event and does not set `sc_flag`.
- R3: With `cfg_detect_en` high, a received character equal in all bits to `xoff2_chr` sets `sc_flag` one clock later. Bit 0 of the register is compared with bit 0 of the character.
- R4: With `cfg_detect_en` low, `sc_flag` is never set. Under mode 2'b10 a character equal to `xoff2_chr` is stored like any other.
- R5: Mode 2'b10 selects pair A. A character equal to `xoff1_chr` or `xon1_chr` is not stored and pulses `xoff_evt` or `xon_evt` one clock later. A character equal to `xoff2_chr` (and to neither pair-A value) is stored.
- R6: Mode 2'b01 selects pair B. A character equal to `xoff2_chr` is not stored, pulses `xoff_evt`, and also sets `sc_flag` if detection is enabled. A character equal to `xon2_chr` is not stored and pulses `xon_evt`. Pair-A values are stored.
- R7: Modes 2'b00 and 2'b11 disable flow control. No XON/XOFF events occur, flow-control values are stored, and `tx_pause` is low from the clock after the mode is selected.
- R8: `tx_pause` rises in the same cycle as an `xoff_evt` pulse and falls in the same cycle as an `xon_evt` pulse. Otherwise it holds.
- R9: `sc_flag` stays set until a cycle with `status_rd` high. It is low from the following clock, unless a new match arrives in that same cycle, in which case it stays set.
- R10: `sc_irq` is high exactly when `sc_flag` and `cfg_ie_special` are both high. The enable does not change `sc_flag`.
- R11: If a character equals both the XON and the XOFF value of the active pair, it is treated as XOFF only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_byte | input | W | Received character |
| rx_frame_err | input | 1 | Character had a framing error |
| cfg_detect_en | input | 1 | Special-character detection enable |
| cfg_fc_mode | input | 2 | Compare mode: 10 pair A, 01 pair B, 00/11 off |
| cfg_ie_special | input | 1 | Special-character interrupt enable |
| xon1_chr | input | W | Pair A XON value |
| xon2_chr | input | W | Pair B XON value |
| xoff1_chr | input | W | Pair A XOFF value |
| xoff2_chr | input | W | Pair B XOFF value and special-character value |
| status_rd | input | 1 | Status read strobe, clears the flag |
| fifo_wr | output | 1 | Write strobe toward the receive FIFO |
| fifo_data | output | W | Character toward the receive FIFO |
| xoff_evt | output | 1 | One-cycle XOFF received event |
| xon_evt | output | 1 | One-cycle XON received event |
| sc_flag | output | 1 | Sticky special-character detected flag |
| sc_irq | output | 1 | Special-character interrupt request |
| tx_pause | output | 1 | Hold request to the transmitter |

## Verification
The bench sends the shared XOFF2/special value under both modes. A design that mixed up the mode would store the character under pair B, or swallow it under pair A. It sends that value with a framing error, and with detection disabled; a wrong design would set the flag or fire an event there. It issues a status read in the same cycle as a new match, where a design with the wrong priority would lose the flag. It also programs a pair whose XON and XOFF values are equal, where a design would fire both events or resume the transmitter. Back-to-back characters and a switch to the off mode while paused check that the pipeline and `tx_pause` do not drop or hold stale state.

// File: rtl/rxsc_pkg.sv
package rxsc_pkg;

  typedef enum logic [1:0] {
    FC_OFF    = 2'b00,
    FC_PAIR_B = 2'b01,
    FC_PAIR_A = 2'b10,
    FC_OFF_ALT = 2'b11
  } fc_mode_e;

  typedef struct packed {
    logic hit_xoff;
    logic hit_xon;
    logic hit_special;
    logic drop;
  } rx_class_t;

  function automatic logic flow_active(input fc_mode_e m);
    return (m == FC_PAIR_A) || (m == FC_PAIR_B);
  endfunction

  function automatic logic pick_pair_a(input fc_mode_e m);
    return m == FC_PAIR_A;
  endfunction

endpackage

// File: rtl/rxsc_compare.sv
module rxsc_compare #(
  parameter int W = 8
) (
  input  logic [W-1:0]        chr,
  input  logic                ferr,
  input  logic [1:0]          mode,
  input  logic                det_en,
  input  logic [W-1:0]        xon_a,
  input  logic [W-1:0]        xon_b,
  input  logic [W-1:0]        xoff_a,
  input  logic [W-1:0]        xoff_b,
  output rxsc_pkg::rx_class_t cls
);
  import rxsc_pkg::*;

  fc_mode_e     m;
  logic         flow_on;
  logic [W-1:0] xon_sel;
  logic [W-1:0] xoff_sel;
  logic [W-1:0] diff_xon;
  logic [W-1:0] diff_xoff;
  logic [W-1:0] diff_sp;

  assign m        = fc_mode_e'(mode);
  assign flow_on  = flow_active(m);
  assign xon_sel  = pick_pair_a(m) ? xon_a  : xon_b;
  assign xoff_sel = pick_pair_a(m) ? xoff_a : xoff_b;

  // bitwise compare, one lane per character bit
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign diff_xon[i]  = chr[i] ^ xon_sel[i];
    assign diff_xoff[i] = chr[i] ^ xoff_sel[i];
    assign diff_sp[i]   = chr[i] ^ xoff_b[i];
  end

  always_comb begin
    cls.hit_xoff    = flow_on & ~ferr & ~|diff_xoff;
    cls.hit_xon     = flow_on & ~ferr & ~|diff_xon & |diff_xoff;
    cls.hit_special = det_en  & ~ferr & ~|diff_sp;
    cls.drop        = cls.hit_xoff | cls.hit_xon;
  end

endmodule

// File: rtl/rxsc_status.sv
module rxsc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/rxsc_flow.sv
module rxsc_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic flow_on,
  input  logic pause_i,
  input  logic resume_i,
  output logic pause_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pause_o <= 1'b0;
    else if (!flow_on)  pause_o <= 1'b0;
    else if (pause_i)   pause_o <= 1'b1;
    else if (resume_i)  pause_o <= 1'b0;
  end
endmodule

// File: rtl/rx_special_char.sv
module rx_special_char #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  input  logic         rx_frame_err,
  input  logic         cfg_detect_en,
  input  logic [1:0]   cfg_fc_mode,
  input  logic         cfg_ie_special,
  input  logic [W-1:0] xon1_chr,
  input  logic [W-1:0] xon2_chr,
  input  logic [W-1:0] xoff1_chr,
  input  logic [W-1:0] xoff2_chr,
  input  logic         status_rd,
  output logic         fifo_wr,
  output logic [W-1:0] fifo_data,
  output logic         xoff_evt,
  output logic         xon_evt,
  output logic         sc_flag,
  output logic         sc_irq,
  output logic         tx_pause
);
  import rxsc_pkg::*;

  rx_class_t cls;
  // named internal events for the checker
  logic take_xoff;
  logic take_xon;
  logic take_special;
  logic drop_char;
  logic flow_on;

  rxsc_compare #(.W(W)) u_cmp (
    .chr    (rx_byte),
    .ferr   (rx_frame_err),
    .mode   (cfg_fc_mode),
    .det_en (cfg_detect_en),
    .xon_a  (xon1_chr),
    .xon_b  (xon2_chr),
    .xoff_a (xoff1_chr),
    .xoff_b (xoff2_chr),
    .cls    (cls)
  );

  assign flow_on      = flow_active(fc_mode_e'(cfg_fc_mode));
  assign take_xoff    = rx_valid & cls.hit_xoff;
  assign take_xon     = rx_valid & cls.hit_xon;
  assign take_special = rx_valid & cls.hit_special;
  assign drop_char    = cls.drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
      xoff_evt  <= 1'b0;
      xon_evt   <= 1'b0;
    end else begin
      fifo_wr  <= rx_valid & ~drop_char;
      xoff_evt <= take_xoff;
      xon_evt  <= take_xon;
      if (rx_valid & ~drop_char) fifo_data <= rx_byte;
    end
  end

  rxsc_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (take_special),
    .clr_i  (status_rd),
    .flag_o (sc_flag)
  );

  rxsc_flow u_flow (
    .clk      (clk),
    .rst_n    (rst_n),
    .flow_on  (flow_on),
    .pause_i  (take_xoff),
    .resume_i (take_xon),
    .pause_o  (tx_pause)
  );

  assign sc_irq = sc_flag & cfg_ie_special;

endmodule

// File: rtl/rxsc_checker.sv
module rxsc_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rx_valid,
  input logic [W-1:0] rx_byte,
  input logic         rx_frame_err,
  input logic         cfg_detect_en,
  input logic [1:0]   cfg_fc_mode,
  input logic [W-1:0] xon1_chr,
  input logic [W-1:0] xoff1_chr,
  input logic [W-1:0] xoff2_chr,
  input logic         status_rd,
  input logic         drop_char,
  input logic         fifo_wr,
  input logic [W-1:0] fifo_data,
  input logic         xoff_evt,
  input logic         xon_evt,
  input logic         sc_flag,
  input logic         sc_irq,
  input logic         tx_pause
);

  // R1
  no_spurious_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !fifo_wr);

  // R1
  keep_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !drop_char) |=> (fifo_wr && fifo_data == $past(rx_byte)));

  // R2
  frame_err_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_frame_err) |=> (fifo_wr && !xoff_evt && !xon_evt));

  // R3
  special_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_detect_en && !rx_frame_err && rx_byte == xoff2_chr) |=> sc_flag);

  // R4
  detect_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_detect_en && !sc_flag) |=> !sc_flag);

  // R5
  pair_a_keeps_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_fc_mode == 2'b10 && rx_byte == xoff2_chr &&
     rx_byte != xoff1_chr && rx_byte != xon1_chr) |=> fifo_wr);

  // R6
  pair_b_swallows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_fc_mode == 2'b01 && !rx_frame_err && rx_byte == xoff2_chr)
      |=> (xoff_evt && !fifo_wr));

  // R7
  off_mode_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fc_mode == 2'b00 || cfg_fc_mode == 2'b11) |=> (!tx_pause && !xoff_evt && !xon_evt));

  // R8
  pause_tracks_xoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_evt |-> tx_pause);

  // R8
  resume_tracks_xon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xon_evt |-> !tx_pause);

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !(rx_valid && cfg_detect_en && !rx_frame_err && rx_byte == xoff2_chr))
      |=> !sc_flag);

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_irq |-> sc_flag);

  // R11
  xoff_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_fc_mode == 2'b10 && !rx_frame_err &&
     rx_byte == xoff1_chr && rx_byte == xon1_chr) |=> (xoff_evt && !xon_evt));

endmodule

bind rx_special_char rxsc_checker #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_valid      (rx_valid),
  .rx_byte       (rx_byte),
  .rx_frame_err  (rx_frame_err),
  .cfg_detect_en (cfg_detect_en),
  .cfg_fc_mode   (cfg_fc_mode),
  .xon1_chr      (xon1_chr),
  .xoff1_chr     (xoff1_chr),
  .xoff2_chr     (xoff2_chr),
  .status_rd     (status_rd),
  .drop_char     (drop_char),
  .fifo_wr       (fifo_wr),
  .fifo_data     (fifo_data),
  .xoff_evt      (xoff_evt),
  .xon_evt       (xon_evt),
  .sc_flag       (sc_flag),
  .sc_irq        (sc_irq),
  .tx_pause      (tx_pause)
);

// File: tb/rx_special_char_bench.sv
module rx_special_char_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rx_valid = 1'b0;
  logic [W-1:0] rx_byte = '0;
  logic         rx_frame_err = 1'b0;
  logic         cfg_detect_en = 1'b0;
  logic [1:0]   cfg_fc_mode = 2'b00;
  logic         cfg_ie_special = 1'b0;
  logic [W-1:0] xon1_chr = 8'h11;
  logic [W-1:0] xon2_chr = 8'h91;
  logic [W-1:0] xoff1_chr = 8'h13;
  logic [W-1:0] xoff2_chr = 8'h93;
  logic         status_rd = 1'b0;
  logic         fifo_wr;
  logic [W-1:0] fifo_data;
  logic         xoff_evt;
  logic         xon_evt;
  logic         sc_flag;
  logic         sc_irq;
  logic         tx_pause;

  always #5 clk = ~clk;

  rx_special_char #(.W(W)) u_rx_special_char (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_frame_err(rx_frame_err), .cfg_detect_en(cfg_detect_en),
    .cfg_fc_mode(cfg_fc_mode), .cfg_ie_special(cfg_ie_special),
    .xon1_chr(xon1_chr), .xon2_chr(xon2_chr), .xoff1_chr(xoff1_chr),
    .xoff2_chr(xoff2_chr), .status_rd(status_rd), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .xoff_evt(xoff_evt), .xon_evt(xon_evt),
    .sc_flag(sc_flag), .sc_irq(sc_irq), .tx_pause(tx_pause)
  );

  typedef struct {
    logic         wr;
    logic [W-1:0] data;
    logic         xoff;
    logic         xon;
    logic         flag;
    logic         irq;
    logic         pause;
    string        req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  logic m_pause = 1'b0;
  logic m_flag  = 1'b0;
  bit   done = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: present one character at a falling edge and queue its expected result
  task automatic send(logic [W-1:0] b, logic ferr, logic rd, string req);
    exp_t e;
    logic flow, xo, xn, sp;
    logic [W-1:0] xs, ns;
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; rx_frame_err = ferr; status_rd = rd;
    flow = (cfg_fc_mode == 2'b01) || (cfg_fc_mode == 2'b10);
    xs   = (cfg_fc_mode == 2'b10) ? xoff1_chr : xoff2_chr;
    ns   = (cfg_fc_mode == 2'b10) ? xon1_chr  : xon2_chr;
    xo   = flow && !ferr && (b == xs);
    xn   = flow && !ferr && (b == ns) && !xo;
    sp   = cfg_detect_en && !ferr && (b == xoff2_chr);
    if (!flow)   m_pause = 1'b0;
    else if (xo) m_pause = 1'b1;
    else if (xn) m_pause = 1'b0;
    if (sp)      m_flag = 1'b1;
    else if (rd) m_flag = 1'b0;
    e.wr = !(xo || xn); e.data = b; e.xoff = xo; e.xon = xn;
    e.flag = m_flag; e.irq = m_flag && cfg_ie_special; e.pause = m_pause; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    rx_valid = 1'b0; rx_frame_err = 1'b0; status_rd = 1'b0;
  endtask

  task automatic read_status(string req);
    @(negedge clk);
    rx_valid = 1'b0; status_rd = 1'b1;
    m_flag = 1'b0;
    @(negedge clk);
    status_rd = 1'b0;
    chk(req, "sc_flag after read", sc_flag, 0);
  endtask

  task automatic set_mode(logic [1:0] mode, logic det, logic ie, string req);
    @(negedge clk);
    rx_valid = 1'b0;
    cfg_fc_mode = mode; cfg_detect_en = det; cfg_ie_special = ie;
    if (!(mode == 2'b01 || mode == 2'b10)) m_pause = 1'b0;
    @(negedge clk);
    chk(req, "tx_pause after mode", tx_pause, m_pause);
    chk("R10", "sc_irq after mode", sc_irq, m_flag && ie);
  endtask

  // monitor: pop and compare one result per accepted character
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n) begin
        logic took;
        took = rx_valid;
        @(negedge clk);
        if (took) begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.req, "fifo_wr", fifo_wr, e.wr);
          if (e.wr) chk(e.req, "fifo_data", fifo_data, e.data);
          chk(e.req, "xoff_evt", xoff_evt, e.xoff);
          chk(e.req, "xon_evt", xon_evt, e.xon);
          chk(e.req, "sc_flag", sc_flag, e.flag);
          chk("R10", "sc_irq", sc_irq, e.irq);
          chk("R8", "tx_pause", tx_pause, e.pause);
        end else begin
          chk("R1", "idle fifo_wr", fifo_wr, 0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset fifo_wr", fifo_wr, 0);
    chk("R9", "reset sc_flag", sc_flag, 0);
    chk("R8", "reset tx_pause", tx_pause, 0);
    chk("R10", "reset sc_irq", sc_irq, 0);
    rst_n = 1'b1;

    // pair A, detection on
    set_mode(2'b10, 1'b1, 1'b1, "R5");
    send(8'h41, 0, 0, "R1");
    send(8'h13, 0, 0, "R5");
    send(8'h11, 0, 0, "R5");
    send(8'h93, 0, 0, "R5");
    idle();
    read_status("R9");
    send(8'h93, 1, 0, "R2");
    send(8'h13, 1, 0, "R2");
    idle();

    // pair B
    set_mode(2'b01, 1'b1, 1'b1, "R6");
    send(8'h93, 0, 0, "R6");
    send(8'h13, 0, 0, "R6");
    send(8'h91, 0, 0, "R6");
    idle();
    read_status("R9");

    // detection off
    set_mode(2'b01, 1'b0, 1'b1, "R4");
    send(8'h93, 0, 0, "R4");
    set_mode(2'b10, 1'b0, 1'b1, "R4");
    send(8'h93, 0, 0, "R4");
    send(8'hC9, 0, 0, "R3");
    idle();

    // bit order: value differing only in bit 0 must not match
    set_mode(2'b10, 1'b1, 1'b0, "R3");
    send(8'h92, 0, 0, "R3");
    send(8'h93, 0, 0, "R10");
    idle();
    // read in the same cycle as a fresh match: flag stays
    send(8'h93, 0, 1, "R9");
    idle();
    read_status("R9");

    // XON equal to XOFF in the active pair
    @(negedge clk); xon1_chr = 8'h13;
    send(8'h13, 0, 0, "R11");
    idle();
    @(negedge clk); xon1_chr = 8'h11;

    // off modes while paused
    set_mode(2'b00, 1'b1, 1'b1, "R7");
    send(8'h13, 0, 0, "R7");
    send(8'h11, 0, 0, "R7");
    send(8'h93, 0, 0, "R3");
    idle();
    read_status("R9");
    set_mode(2'b01, 1'b1, 1'b1, "R6");
    send(8'h93, 0, 0, "R8");
    idle();
    set_mode(2'b11, 1'b0, 1'b1, "R7");
    send(8'h91, 0, 0, "R7");
    idle();
    repeat (3) @(negedge clk);
    chk("R1", "queue drained", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule